// File: doc/BRIEF.md
# Shadowed SRAM Store/Recall Controller

This block models a byte-wide static memory in which every word has a nonvolatile shadow copy. A clocked SRAM-style port gives normal reads and writes. The port has an address, separate write-data and read-data buses with a read-valid flag, and active-low chip, output and write enables. A STORE copies the whole working array into the shadow array. A RECALL first zeroes the working array and then loads it from the shadow. The shadow array is never altered by a RECALL.

Transfers start in three ways. The first is a software unlock: six consecutive reads that present a fixed address sequence. The second is a rising power-fail input, which starts a STORE. The third is a rising power-good input, which starts a RECALL; this includes power-good already high when reset is released. While a transfer runs, `busy` is high and the memory port ignores every access. The transfer moves one word per clock and then waits a fixed settle count before it drops `busy`. The full-size memory has 8192 words and uses `ADDR_W = 13`. The default of 10 keeps elaboration small. Each unlock address is compared on its low `ADDR_W` bits.

Top module: `nvs_shadow_ctl`

## Requirements
- R1: After reset, `busy` and `dout_en` are low.
- R2: A read is sampled on a clock edge where ce_n=0, we_n=1, oe_n=0 and busy is low. Its data appears on `dout` one cycle later, with `dout_en` high. A write is sampled on a clock edge where ce_n=0 and we_n=0 and busy is low; it stores `din` at `addr`.
- R3: A cycle with oe_n=1 and we_n=1 gives no read data: `dout_en` stays low.
- R4: The unlock prefix is five reads, each started by a falling ce_n with we_n=1, to 0x0E38, 0x11C7, 0x03E0, 0x1C1F and 0x0303, in that order. A sixth read to 0x1C3C then starts a STORE. The sixth read still returns its data. `busy` rises after that edge and stays high for WORDS+SETTLE_CYC cycles.
- R5: The same prefix followed by a sixth read to 0x0C63 starts a RECALL. `busy` stays high for 2*WORDS+SETTLE_CYC cycles: a zeroing pass, then a copy pass. Afterwards every word reads back as the shadow holds it.
- R6: A write access, or a read of an address that is not the next code, aborts the sequence. In that case the sixth code starts nothing.
- R7: While `busy` is high, writes are dropped and reads produce no `dout_en`.
- R8: A rising `pfail` while idle starts a STORE of the same length as R4.
- R9: A rising `pgood` while idle starts a RECALL of the same length as R5. This includes `pgood` already high when reset is released.
- R10: A RECALL leaves the shadow unchanged. A second RECALL after the working array has been overwritten restores the same data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | ADDR_W | Word address |
| din | input | DATA_W | Write data |
| dout | output | DATA_W | Read data, held between reads |
| dout_en | output | 1 | Read data valid |
| pfail | input | 1 | Power-fail indication, rising edge starts STORE |
| pgood | input | 1 | Power-good indication, rising edge starts RECALL |
| busy | output | 1 | A STORE or RECALL is in progress |

## Verification
Read data is due exactly one cycle after the edge that samples the read. The bench queues the expected byte when it drives the read. It compares that byte at the falling edge that follows, where the monitor also flags any `dout_en` that has no queued item. `busy` is due high one cycle after the triggering edge, which is either the sixth read or the `pfail`/`pgood` rise. The bench then counts every falling edge at which `busy` is high and compares the count with WORDS+SETTLE_CYC for a STORE and 2*WORDS+SETTLE_CYC for a RECALL. That count exposes a missing or extra phase. Writes driven during `busy` are checked later by reading back the old data.

// File: rtl/nvs_pkg.sv
package nvs_pkg;

    typedef enum logic [2:0] {
        XF_IDLE,
        XF_STORE,
        XF_CLEAR,
        XF_COPY,
        XF_SETTLE
    } xf_state_e;

    typedef enum logic [1:0] {
        OP_NONE,
        OP_SAVE,
        OP_ZERO,
        OP_LOAD
    } arr_op_e;

    localparam int CODE_W     = 13;
    localparam int PREFIX_LEN = 5;

    localparam logic [CODE_W-1:0] SAVE_TAIL = 13'h1C3C;
    localparam logic [CODE_W-1:0] LOAD_TAIL = 13'h0C63;

    // prefix address for step idx of the unlock sequence
    function automatic logic [CODE_W-1:0] prefix_code(input int idx);
        logic [CODE_W-1:0] c;
        case (idx)
            0:       c = 13'h0E38;
            1:       c = 13'h11C7;
            2:       c = 13'h03E0;
            3:       c = 13'h1C1F;
            4:       c = 13'h0303;
            default: c = '1;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/nvs_unlock.sv
module nvs_unlock
    import nvs_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              hold,
    output logic              sw_store,
    output logic              sw_recall
);

    localparam int STEP_W = $clog2(PREFIX_LEN + 1);

    typedef struct packed {
        logic              ce_n;
        logic [STEP_W-1:0] step;
    } unl_t;

    unl_t q, d;
    logic fall;
    logic hit_next, hit_first, hit_save, hit_load;

    always_comb begin
        logic [CODE_W-1:0] want;
        logic [CODE_W-1:0] first;
        logic [CODE_W-1:0] s_tail;
        logic [CODE_W-1:0] l_tail;
        want   = prefix_code(int'(q.step));
        first  = prefix_code(0);
        s_tail = SAVE_TAIL;
        l_tail = LOAD_TAIL;
        fall      = q.ce_n && !ce_n;
        hit_next  = (addr == want[ADDR_W-1:0]);
        hit_first = (addr == first[ADDR_W-1:0]);
        hit_save  = (addr == s_tail[ADDR_W-1:0]);
        hit_load  = (addr == l_tail[ADDR_W-1:0]);

        d         = q;
        d.ce_n    = ce_n;
        sw_store  = 1'b0;
        sw_recall = 1'b0;

        if (hold) begin
            d.step = '0;
        end else if (fall) begin
            if (!we_n) begin
                d.step = '0;
            end else if (int'(q.step) < PREFIX_LEN && hit_next) begin
                d.step = q.step + 1'b1;
            end else if (int'(q.step) == PREFIX_LEN && (hit_save || hit_load)) begin
                sw_store  = hit_save;
                sw_recall = hit_load;
                d.step    = '0;
            end else begin
                d.step = hit_first ? STEP_W'(1) : '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.ce_n <= 1'b1;
            q.step <= '0;
        end else begin
            q <= d;
        end
    end

    AST_STEP_CLR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> (q.step == '0)); // R6

    AST_WRITE_ABORTS: assert property (@(posedge clk) disable iff (!rst_n)
        (fall && !we_n) |=> (q.step == '0)); // R6

endmodule

// File: rtl/nvs_xfer.sv
module nvs_xfer
    import nvs_pkg::*;
#(
    parameter int ADDR_W     = 10,
    parameter int SETTLE_CYC = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pfail,
    input  logic              pgood,
    input  logic              sw_store,
    input  logic              sw_recall,
    output logic              busy,
    output arr_op_e           op,
    output logic [ADDR_W-1:0] ptr
);

    localparam int                WAIT_W = $clog2(SETTLE_CYC + 1);
    localparam logic [ADDR_W-1:0] LAST   = '1;

    typedef struct packed {
        xf_state_e         st;
        logic [ADDR_W-1:0] ptr;
        logic [WAIT_W-1:0] wcnt;
        logic              pfail;
        logic              pgood;
    } xf_t;

    xf_t q, d;
    logic auto_store, auto_recall;

    always_comb begin
        auto_store  = pfail && !q.pfail;
        auto_recall = pgood && !q.pgood;

        d       = q;
        d.pfail = pfail;
        d.pgood = pgood;

        case (q.st)
            XF_IDLE: begin
                d.ptr  = '0;
                d.wcnt = '0;
                if (auto_store || sw_store)        d.st = XF_STORE;
                else if (auto_recall || sw_recall) d.st = XF_CLEAR;
            end
            XF_STORE: begin
                d.ptr = q.ptr + 1'b1;
                if (q.ptr == LAST) d.st = XF_SETTLE;
            end
            XF_CLEAR: begin
                d.ptr = q.ptr + 1'b1;
                if (q.ptr == LAST) d.st = XF_COPY;
            end
            XF_COPY: begin
                d.ptr = q.ptr + 1'b1;
                if (q.ptr == LAST) d.st = XF_SETTLE;
            end
            XF_SETTLE: begin
                d.wcnt = q.wcnt + 1'b1;
                if (int'(q.wcnt) == SETTLE_CYC - 1) d.st = XF_IDLE;
            end
            default: d.st = XF_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.st    <= XF_IDLE;
            q.ptr   <= '0;
            q.wcnt  <= '0;
            q.pfail <= 1'b0;
            q.pgood <= 1'b0;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        busy = (q.st != XF_IDLE);
        ptr  = q.ptr;
        case (q.st)
            XF_STORE: op = OP_SAVE;
            XF_CLEAR: op = OP_ZERO;
            XF_COPY:  op = OP_LOAD;
            default:  op = OP_NONE;
        endcase
    end

    AST_START_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(sw_store || sw_recall || pfail || pgood)); // R4

    AST_COPY_AFTER_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == XF_COPY) |-> $past(q.st == XF_CLEAR || q.st == XF_COPY)); // R5

    AST_SAVE_NOT_FROM_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == XF_STORE) |-> $past(q.st == XF_IDLE || q.st == XF_STORE)); // R8

endmodule

// File: rtl/nvs_shadow_ctl.sv
module nvs_shadow_ctl
    import nvs_pkg::*;
#(
    parameter int ADDR_W     = 10,
    parameter int DATA_W     = 8,
    parameter int SETTLE_CYC = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout,
    output logic              dout_en,
    input  logic              pfail,
    input  logic              pgood,
    output logic              busy
);

    localparam int WORDS = 1 << ADDR_W;

    typedef struct packed {
        logic [DATA_W-1:0] dout;
        logic              dout_en;
    } rd_t;

    logic [DATA_W-1:0] sram_mem   [WORDS];
    logic [DATA_W-1:0] shadow_mem [WORDS];

    rd_t               q, d;
    logic              sw_store, sw_recall;
    arr_op_e           op;
    logic [ADDR_W-1:0] xptr;
    logic              user_rd, user_wr;

    nvs_unlock #(.ADDR_W(ADDR_W)) unlock_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .ce_n      (ce_n),
        .we_n      (we_n),
        .addr      (addr),
        .hold      (busy),
        .sw_store  (sw_store),
        .sw_recall (sw_recall)
    );

    nvs_xfer #(.ADDR_W(ADDR_W), .SETTLE_CYC(SETTLE_CYC)) xfer_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .pfail     (pfail),
        .pgood     (pgood),
        .sw_store  (sw_store),
        .sw_recall (sw_recall),
        .busy      (busy),
        .op        (op),
        .ptr       (xptr)
    );

    always_comb begin
        user_rd   = !busy && !ce_n && we_n && !oe_n;
        user_wr   = !busy && !ce_n && !we_n;
        d         = q;
        d.dout_en = user_rd;
        if (user_rd) d.dout = sram_mem[addr];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.dout    <= '0;
            q.dout_en <= 1'b0;
        end else begin
            q <= d;
        end
    end

    // arrays carry no reset: contents survive reset like the modelled cells
    always_ff @(posedge clk) begin
        case (op)
            OP_SAVE: shadow_mem[xptr] <= sram_mem[xptr];
            OP_ZERO: sram_mem[xptr]   <= '0;
            OP_LOAD: sram_mem[xptr]   <= shadow_mem[xptr];
            default: if (user_wr) sram_mem[addr] <= din;
        endcase
    end

    assign dout    = q.dout;
    assign dout_en = q.dout_en;

    AST_QUIET_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !dout_en); // R7

    AST_OE_GATES_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (oe_n && we_n) |=> !dout_en); // R3

    AST_DOUT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !dout_en |-> $stable(dout)); // R2

endmodule

// File: tb/nvs_shadow_ctl_tb.sv
module nvs_shadow_ctl_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 10;
    localparam int DATA_W     = 8;
    localparam int SETTLE_CYC = 8;
    localparam int WORDS      = 1 << ADDR_W;
    localparam int STORE_LEN  = WORDS + SETTLE_CYC;
    localparam int RECALL_LEN = 2 * WORDS + SETTLE_CYC;
    localparam int AMASK      = WORDS - 1;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              ce_n, oe_n, we_n;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] din;
    logic [DATA_W-1:0] dout;
    logic              dout_en;
    logic              pfail, pgood;
    logic              busy;

    int errors = 0;
    int checks = 0;
    bit done   = 0;

    logic [DATA_W-1:0] sram_m [WORDS];
    logic [DATA_W-1:0] shad_m [WORDS];
    bit                known  [WORDS];
    logic [DATA_W-1:0] exp_q  [$];

    always #(CLK_PERIOD/2) clk = ~clk;

    nvs_shadow_ctl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SETTLE_CYC(SETTLE_CYC)) dut_i (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .addr(addr), .din(din), .dout(dout), .dout_en(dout_en),
        .pfail(pfail), .pgood(pgood), .busy(busy)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // monitor: compares every read result against the scoreboard
    always @(negedge clk) begin
        if (rst_n && dout_en && !done) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R7 unexpected dout_en", 1, 0);
            end else begin
                logic [DATA_W-1:0] e;
                e = exp_q.pop_front();
                check(dout == e, "R2 read data", int'(dout), int'(e));
            end
        end
    end

    function automatic logic [ADDR_W-1:0] code_at(input int i);
        logic [12:0] c;
        case (i)
            0: c = 13'h0E38; 1: c = 13'h11C7; 2: c = 13'h03E0;
            3: c = 13'h1C1F; 4: c = 13'h0303; 5: c = 13'h1C3C;
            default: c = 13'h0C63;
        endcase
        return c[ADDR_W-1:0];
    endfunction

    task automatic wr(input int a, input int v, input bit ign);
        @(negedge clk);
        ce_n = 0; we_n = 0; oe_n = 1; addr = ADDR_W'(a); din = DATA_W'(v);
        @(negedge clk);
        ce_n = 1; we_n = 1;
        if (!ign) begin
            sram_m[a & AMASK] = DATA_W'(v);
            known[a & AMASK]  = 1;
        end
    endtask

    task automatic rd(input int a, input bit ign);
        @(negedge clk);
        ce_n = 0; we_n = 1; oe_n = 0; addr = ADDR_W'(a);
        if (!ign && known[a & AMASK]) exp_q.push_back(sram_m[a & AMASK]);
        else if (!ign) exp_q.push_back('0);
        @(negedge clk);
        ce_n = 1; oe_n = 1;
    endtask

    task automatic run_seq(input int tail);
        for (int i = 0; i < 5; i++) rd(int'(code_at(i)), 0);
        rd(int'(code_at(tail)), 0);
    endtask

    task automatic measure_busy(input int exp_len, input string req);
        int cnt = 0;
        while (busy && cnt < 4 * WORDS + 100) begin
            cnt++;
            @(negedge clk);
        end
        check(cnt == exp_len, req, cnt, exp_len);
    endtask

    task automatic readback(input string req);
        for (int i = 0; i < WORDS; i++) begin
            if (known[i]) rd(i, 0);
        end
        @(negedge clk);
        check(exp_q.size() == 0, req, exp_q.size(), 0);
    endtask

    task automatic fill(input int seed);
        for (int i = 0; i < 12; i++) wr((i * 83 + 5) & AMASK, (i * 29 + seed) & 8'hFF, 0);
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        check(1'b0, "watchdog", 0, 1);
        finish_run();
    end

    initial begin
        for (int i = 0; i < WORDS; i++) known[i] = 0;
        rst_n = 0; ce_n = 1; oe_n = 1; we_n = 1; addr = '0; din = '0;
        pfail = 0; pgood = 0;
        repeat (3) @(negedge clk);
        check(!busy, "R1 busy after reset", int'(busy), 0);
        check(!dout_en, "R1 dout_en after reset", int'(dout_en), 0);
        rst_n = 1;
        @(negedge clk);

        // R2: plain writes and reads, two patterns
        fill(7);
        wr(0, 8'h00, 0); wr(AMASK, 8'hFF, 0); wr(1, 8'hA5, 0);
        readback("R2 reads drained");

        // R3: output enable high gives no data
        @(negedge clk);
        ce_n = 0; we_n = 1; oe_n = 1; addr = ADDR_W'(1);
        @(negedge clk);
        check(!dout_en, "R3 no data with oe_n high", int'(dout_en), 0);
        ce_n = 1;

        // R4: software store
        run_seq(5);
        check(busy, "R4 busy after store code", int'(busy), 1);
        measure_busy(STORE_LEN, "R4 store length");
        for (int i = 0; i < WORDS; i++) shad_m[i] = sram_m[i];

        // R6: aborted sequences after changing the working data
        fill(101);
        for (int i = 0; i < 3; i++) rd(int'(code_at(i)), 0);
        wr(2, 8'h3C, 0);
        for (int i = 3; i < 5; i++) rd(int'(code_at(i)), 0);
        rd(int'(code_at(5)), 0);
        @(negedge clk);
        check(!busy, "R6 write aborts sequence", int'(busy), 0);
        for (int i = 0; i < 2; i++) rd(int'(code_at(i)), 0);
        rd(9, 0);
        for (int i = 2; i < 5; i++) rd(int'(code_at(i)), 0);
        rd(int'(code_at(5)), 0);
        @(negedge clk);
        check(!busy, "R6 stray read aborts sequence", int'(busy), 0);

        // R5: software recall brings back the stored data, not the aborted one
        run_seq(6);
        check(busy, "R5 busy after recall code", int'(busy), 1);
        measure_busy(RECALL_LEN, "R5 recall length");
        for (int i = 0; i < WORDS; i++) sram_m[i] = shad_m[i];
        readback("R5 recall data");

        // R7: accesses during a transfer are ignored
        run_seq(5);
        wr(1, 8'h77, 1);
        rd(1, 1);
        measure_busy(STORE_LEN - 4, "R7 store length with ignored accesses");
        rd(1, 0);
        @(negedge clk);
        check(exp_q.size() == 0, "R7 write dropped", exp_q.size(), 0);

        // R8: power-fail store
        fill(55);
        pfail = 1;
        @(negedge clk);
        check(busy, "R8 busy after pfail", int'(busy), 1);
        measure_busy(STORE_LEN, "R8 pfail store length");
        for (int i = 0; i < WORDS; i++) shad_m[i] = sram_m[i];
        pfail = 0;

        // R9: power-good recall
        fill(200);
        pgood = 1;
        @(negedge clk);
        check(busy, "R9 busy after pgood", int'(busy), 1);
        measure_busy(RECALL_LEN, "R9 pgood recall length");
        for (int i = 0; i < WORDS; i++) sram_m[i] = shad_m[i];
        readback("R9 pgood recall data");

        // R10: recall leaves shadow intact; repeat after overwrite
        fill(33);
        run_seq(6);
        measure_busy(RECALL_LEN, "R10 second recall length");
        for (int i = 0; i < WORDS; i++) sram_m[i] = shad_m[i];
        readback("R10 repeated recall data");

        // R9: pgood already high at reset release
        fill(90);
        rst_n = 0;
        @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check(busy, "R9 recall at power-up", int'(busy), 1);
        measure_busy(RECALL_LEN, "R9 power-up recall length");
        for (int i = 0; i < WORDS; i++) sram_m[i] = shad_m[i];
        readback("R9 power-up recall data");

        finish_run();
    end

endmodule